// File: doc/BRIEF.md
# Ping-Pong Buffer to Transmit FIFO Feeder

This block keeps a transmit FIFO supplied from a pair of on-chip block buffers that alternate between two roles. A producer writes words one after another into the buffer chosen by a select flag. When the producer signals that its block is finished, that buffer is handed to the read side and the flag turns over, so the next block goes into the other buffer. The read side never touches the buffer that is being filled.

The FIFO reports its fill level back to the block. Whenever the feeder is idle, holds a finished buffer and sees fewer than half the FIFO entries occupied, it copies a fixed burst of words from that buffer into the FIFO, one word per clock. The feeder counts the words left in the buffer. When a burst leaves none, the buffer is released and the feeder waits for the producer's next finished block.

Two sticky flags report a producer that finishes too early (overrun) and a FIFO that needs data when no finished buffer exists (underrun). A clear input resets both flags.

Top module: `pingpong_feeder`

## Requirements
- R1: During and after reset, fifoWrEn is 0, wrSel is 0, underrun and overrun are 0, and neither buffer counts as finished, so no FIFO write happens until a block has been finished.
- R2: Producer words go to the buffer selected by wrSel, starting at address 0. A prodDone pulse accepted while the read side holds no finished buffer marks the written buffer as finished and inverts wrSel on the next edge. wrSel changes only because of a prodDone.
- R3: A burst starts only when the feeder is idle, a finished buffer is present and fifoLevel is below half the FIFO depth (32 of 64). At 32 or more, no write is issued.
- R4: A burst writes exactly 32 words, at most one per clock, in ascending buffer-address order, taken from the buffer not selected by wrSel.
- R5: fifoWrEn is never high while fifoFull is high. A burst that is held by fifoFull resumes afterwards without losing or repeating a word.
- R6: The buffer depth (64 words by default) is a multiple of 32. After depth/32 bursts the buffer is released and no further writes occur until another block is finished.
- R7: A prodDone that arrives while the read buffer still holds unsent words sets overrun and drops the new block. wrSel stays the same, and the producer's next words restart at address 0 of the same buffer.
- R8: Once a first block has been accepted, underrun is set if the feeder is idle with no finished buffer and fifoLevel is below 32. It then stays set until it is cleared.
- R9: A clrFlags pulse clears underrun and overrun on the next edge.
- R10: Across successive ping-pong blocks, the words reach the FIFO write port in exactly the order the producer wrote the accepted blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| prodValid | input | 1 | Producer word write strobe |
| prodData | input | 32 | Producer word |
| prodDone | input | 1 | Producer has finished its current block |
| clrFlags | input | 1 | Clears underrun and overrun |
| fifoLevel | input | 7 | Current FIFO occupancy |
| fifoFull | input | 1 | FIFO cannot accept a word |
| fifoWrEn | output | 1 | FIFO write strobe |
| fifoWrData | output | 32 | FIFO write word |
| wrSel | output | 1 | Buffer currently assigned to the producer |
| underrun | output | 1 | Sticky: refill due with no finished buffer |
| overrun | output | 1 | Sticky: a finished block was dropped |

## Verification
The properties assume the following about the inputs:
- prodDone is a single-cycle pulse that never coincides with prodValid.
- fifoFull, fifoLevel and the FIFO's writes stay consistent with each other.
- The producer writes no more than one buffer depth of words per block.

The stimulus respects these assumptions. It drives every input one nanosecond after the rising edge and models the FIFO level as a register that counts the block's own writes. The level is forced to a chosen value only while the feeder is idle, and an extra full-hold input produces the stall case.

// File: rtl/feeder_pkg.sv
package feeder_pkg;
  typedef struct packed {
    logic prodWr;
    logic prodRestart;
    logic issue;
    logic rdRestart;
  } feedStrobes_t;

  typedef enum logic {
    FEED_IDLE  = 1'b0,
    FEED_BURST = 1'b1
  } feedState_t;
endpackage

// File: rtl/feeder_ctrl.sv
module feeder_ctrl
  import feeder_pkg::*;
#(
  parameter int BUF_WORDS  = 64,
  parameter int BURST_LEN  = 32,
  parameter int FIFO_DEPTH = 64
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               prodValid,
  input  logic                               prodDone,
  input  logic                               clrFlags,
  input  logic [$clog2(FIFO_DEPTH+1)-1:0]    fifoLevel,
  input  logic                               fifoFull,
  output feedStrobes_t                       strobes,
  output logic                               wrSel,
  output logic                               underrun,
  output logic                               overrun
);
  localparam int LVL_W  = $clog2(FIFO_DEPTH + 1);
  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam int REM_W  = $clog2(BUF_WORDS + 1);
  localparam int HALF   = FIFO_DEPTH / 2;

  feedState_t        state;
  logic [1:0]        bufValid;
  logic [BEAT_W-1:0] beatCnt;
  logic [REM_W-1:0]  remWords;
  logic              armed;

  logic rdSel, rdReady, lastBeat, issue, finishBuf, accept, needFill;

  always_comb begin
    rdSel     = ~wrSel;
    rdReady   = bufValid[rdSel];
    needFill  = fifoLevel < LVL_W'(HALF);
    lastBeat  = beatCnt == BEAT_W'(BURST_LEN - 1);
    issue     = (state == FEED_BURST) && !fifoFull;
    finishBuf = issue && lastBeat && (remWords == REM_W'(BURST_LEN));
    accept    = prodDone && !rdReady;
    strobes.prodWr      = prodValid;
    strobes.prodRestart = prodDone;
    strobes.issue       = issue;
    strobes.rdRestart   = finishBuf;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= FEED_IDLE;
      wrSel    <= 1'b0;
      bufValid <= 2'b00;
      beatCnt  <= '0;
      remWords <= REM_W'(BUF_WORDS);
      armed    <= 1'b0;
      underrun <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      case (state)
        FEED_IDLE: if (rdReady && needFill) begin
          state   <= FEED_BURST;
          beatCnt <= '0;
        end
        FEED_BURST: if (issue) begin
          beatCnt <= beatCnt + 1'b1;
          if (lastBeat) begin
            state    <= FEED_IDLE;
            remWords <= finishBuf ? REM_W'(BUF_WORDS) : remWords - REM_W'(BURST_LEN);
          end
        end
        default: state <= FEED_IDLE;
      endcase

      if (finishBuf) bufValid[rdSel] <= 1'b0;
      if (accept) begin
        bufValid[wrSel] <= 1'b1;
        wrSel           <= ~wrSel;
        armed           <= 1'b1;
      end

      if (clrFlags) overrun <= 1'b0;
      else if (prodDone && rdReady) overrun <= 1'b1;

      if (clrFlags) underrun <= 1'b0;
      else if (armed && state == FEED_IDLE && !rdReady && needFill) underrun <= 1'b1;
    end
  end
endmodule

// File: rtl/feeder_datapath.sv
module feeder_datapath
  import feeder_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BUF_WORDS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  feedStrobes_t      strobes,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] prodData,
  output logic [DATA_W-1:0] fifoWrData
);
  localparam int ADDR_W = $clog2(BUF_WORDS);

  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;
  logic [DATA_W-1:0] bankOut [2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrAddr <= '0;
      rdAddr <= '0;
    end else begin
      if (strobes.prodRestart) wrAddr <= '0;
      else if (strobes.prodWr) wrAddr <= wrAddr + 1'b1;
      if (strobes.rdRestart) rdAddr <= '0;
      else if (strobes.issue) rdAddr <= rdAddr + 1'b1;
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DATA_W-1:0] mem [BUF_WORDS];
    always_ff @(posedge clk) begin
      if (strobes.prodWr && (wrSel == 1'(b))) mem[wrAddr] <= prodData;
    end
    assign bankOut[b] = mem[rdAddr];
  end

  assign fifoWrData = bankOut[~wrSel];
endmodule

// File: rtl/pingpong_feeder.sv
module pingpong_feeder
  import feeder_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int BUF_WORDS  = 64,
  parameter int BURST_LEN  = 32,
  parameter int FIFO_DEPTH = 64,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              prodValid,
  input  logic [DATA_W-1:0] prodData,
  input  logic              prodDone,
  input  logic              clrFlags,
  input  logic [LVL_W-1:0]  fifoLevel,
  input  logic              fifoFull,
  output logic              fifoWrEn,
  output logic [DATA_W-1:0] fifoWrData,
  output logic              wrSel,
  output logic              underrun,
  output logic              overrun
);
  feedStrobes_t strobes;

  feeder_ctrl #(
    .BUF_WORDS (BUF_WORDS),
    .BURST_LEN (BURST_LEN),
    .FIFO_DEPTH(FIFO_DEPTH)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .prodValid(prodValid),
    .prodDone (prodDone),
    .clrFlags (clrFlags),
    .fifoLevel(fifoLevel),
    .fifoFull (fifoFull),
    .strobes  (strobes),
    .wrSel    (wrSel),
    .underrun (underrun),
    .overrun  (overrun)
  );

  feeder_datapath #(
    .DATA_W   (DATA_W),
    .BUF_WORDS(BUF_WORDS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrSel     (wrSel),
    .prodData  (prodData),
    .fifoWrData(fifoWrData)
  );

  assign fifoWrEn = strobes.issue;
endmodule

// File: rtl/pingpong_feeder_checker.sv
module pingpong_feeder_checker (
  input logic clk,
  input logic rstN,
  input logic prodDone,
  input logic clrFlags,
  input logic fifoFull,
  input logic fifoWrEn,
  input logic wrSel,
  input logic underrun,
  input logic overrun
);
  assert_no_full_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |-> !fifoFull);

  assert_flag_turn_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wrSel) |-> $past(prodDone));

  assert_overrun_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(prodDone));

  assert_underrun_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (underrun && !clrFlags) |=> underrun);

  assert_clear_over_R9: assert property (@(posedge clk) disable iff (!rstN)
    clrFlags |=> !overrun);

  assert_clear_under_R9: assert property (@(posedge clk) disable iff (!rstN)
    clrFlags |=> !underrun);
endmodule

bind pingpong_feeder pingpong_feeder_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .prodDone(prodDone),
  .clrFlags(clrFlags),
  .fifoFull(fifoFull),
  .fifoWrEn(fifoWrEn),
  .wrSel   (wrSel),
  .underrun(underrun),
  .overrun (overrun)
);

// File: tb/pingpong_feeder_tb.sv
module pingpong_feeder_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        prodValid = 1'b0;
  logic [31:0] prodData = '0;
  logic        prodDone = 1'b0;
  logic        clrFlags = 1'b0;
  logic [6:0]  lvl;
  logic        fifoFull;
  logic        holdFull = 1'b0;
  logic        forceLvl = 1'b0;
  logic [6:0]  forceVal = '0;
  logic        fifoWrEn;
  logic [31:0] fifoWrData;
  logic        wrSel, underrun, overrun;

  int checks = 0;
  int fails = 0;
  int writeCount = 0;
  bit finished = 0;
  logic [31:0] expQ [$];

  always #4 clk = ~clk;

  pingpong_feeder u_dut (
    .clk(clk), .rstN(rstN), .prodValid(prodValid), .prodData(prodData),
    .prodDone(prodDone), .clrFlags(clrFlags), .fifoLevel(lvl), .fifoFull(fifoFull),
    .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData), .wrSel(wrSel),
    .underrun(underrun), .overrun(overrun)
  );

  // FIFO occupancy model: counts the block's writes, no draining
  assign fifoFull = (lvl == 7'd64) || holdFull;
  always @(posedge clk) begin
    if (!rstN) lvl <= '0;
    else if (forceLvl) lvl <= forceVal;
    else if (fifoWrEn) lvl <= lvl + 7'd1;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rstN && fifoWrEn) begin
      writeCount++;
      check(!fifoFull, "R5 write while full", 1, 0);
      if (expQ.size() == 0) check(0, "R10 unexpected write", fifoWrData, 0);
      else begin
        logic [31:0] e;
        e = expQ.pop_front();
        check(fifoWrData == e, "R4 R10 word order", fifoWrData, e);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic setLevel(input int v);
    tick(1);
    forceLvl = 1'b1; forceVal = 7'(v);
    tick(1);
    forceLvl = 1'b0;
  endtask

  task automatic writeWords(input logic [31:0] base, input bit push);
    for (int i = 0; i < 64; i++) begin
      tick(1);
      prodValid = 1'b1; prodData = base + 32'(i);
      if (push) expQ.push_back(base + 32'(i));
    end
    tick(1);
    prodValid = 1'b0;
  endtask

  task automatic pulseDone();
    tick(1); prodDone = 1'b1;
    tick(1); prodDone = 1'b0;
  endtask

  task automatic pulseClear();
    tick(1); clrFlags = 1'b1;
    tick(1); clrFlags = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int c0;
    tick(3);
    check(fifoWrEn == 0, "R1 wrEn in reset", fifoWrEn, 0);
    rstN = 1'b1;
    tick(2);
    check(wrSel == 0, "R1 wrSel", wrSel, 0);
    check(!underrun && !overrun, "R1 flags", {underrun, overrun}, 0);
    check(writeCount == 0, "R1 no write without block", writeCount, 0);

    // Block A, level held at 40
    setLevel(40);
    writeWords(32'hA000_0000, 1);
    pulseDone();
    tick(2);
    check(wrSel == 1, "R2 flag turned", wrSel, 1);
    tick(10);
    check(writeCount == 0, "R3 no refill at level 40", writeCount, 0);

    // Level drops: one burst
    setLevel(0);
    tick(40);
    check(writeCount == 32, "R4 burst length", writeCount, 32);
    check(lvl == 32, "R3 stops at half", lvl, 32);

    // Overrun: block B finished while A still holds 32 words
    writeWords(32'hB000_0000, 0);
    pulseDone();
    tick(2);
    check(overrun == 1, "R7 overrun set", overrun, 1);
    check(wrSel == 1, "R7 flag kept", wrSel, 1);
    check(writeCount == 32, "R7 no extra writes", writeCount, 32);
    pulseClear();
    tick(1);
    check(overrun == 0, "R9 overrun cleared", overrun, 0);

    // Second burst of A with a full stall
    setLevel(10);
    tick(12);
    holdFull = 1'b1;
    c0 = writeCount;
    tick(5);
    check(writeCount == c0, "R5 stall holds writes", writeCount, c0);
    holdFull = 1'b0;
    tick(40);
    check(writeCount == 64, "R6 buffer drained", writeCount, 64);
    check(underrun == 0, "R8 no underrun above half", underrun, 0);

    // Underrun: refill due, nothing finished
    setLevel(0);
    tick(3);
    check(underrun == 1, "R8 underrun set", underrun, 1);
    check(writeCount == 64, "R6 waits for next block", writeCount, 64);
    tick(4);
    check(underrun == 1, "R8 underrun held", underrun, 1);
    setLevel(40);
    pulseClear();
    tick(2);
    check(underrun == 0, "R9 underrun cleared", underrun, 0);

    // Block C into buffer 1 (address restart after drop)
    writeWords(32'hC000_0000, 1);
    pulseDone();
    tick(2);
    check(wrSel == 0, "R2 block C accepted", wrSel, 0);
    check(overrun == 0, "R7 no overrun when free", overrun, 0);

    // Drain C while D is written into buffer 0
    fork
      writeWords(32'hD000_0000, 1);
      begin
        setLevel(0); tick(40);
        setLevel(0); tick(40);
      end
    join
    check(writeCount == 128, "R10 block C streamed", writeCount, 128);
    pulseDone();
    tick(2);
    check(wrSel == 1, "R2 block D accepted", wrSel, 1);
    setLevel(0); tick(40);
    setLevel(0); tick(40);
    check(writeCount == 192, "R10 block D streamed", writeCount, 192);
    check(expQ.size() == 0, "R10 all words delivered", expQ.size(), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule